// File: doc/BRIEF.md
# Register File with Deferred Fault Marks

This block is a general-purpose register file in which every register carries a poison bit. A speculative operation that faults, such as a divide by zero or a load that would page-fault, does not trap when it writes. It stores its result and marks the destination register as poisoned. The fault surfaces only when a later instruction consumes that register as a source operand.

The file has two combinational read ports and one write port. Each write carries a fault flag. All poison bits together form one special register that software can read and write as a whole, for context save and restore. A single enable bit selects how a consumed poisoned register is handled:
- When the bit is set, the consumption raises a precise trap request in the same cycle, naming the offending register.
- When the bit is clear, no trap is raised. The register's bit is set in a sticky status vector, and software can inspect or clear that vector later.

Top module: `poisoned_regfile`

## Requirements
- R1: A write with `wr_fault`=1 stores `wr_data` and sets the poison bit of `wr_addr`, visible from the next cycle. It never asserts `trap_req` by itself.
- R2: A write with `wr_fault`=0 stores its data and clears the poison bit of `wr_addr`.
- R3: `mark_rd` presents all poison bits at once, with bit i belonging to register i.
- R4: A pulse on `mark_wr_en` replaces every poison bit with `mark_wr_data` in one cycle, regardless of the data contents of any register.
- R5: A consume is `ra_use` or `rb_use` asserted while the addressed register is poisoned. While `trap_en`=0, a consume leaves `trap_req` at 0 and sets bit i of `status` at the next edge, where i is the consumed register.
- R6: `status` holds a separate bit per register, so only the consumed register's bit changes.
- R7: While `trap_en`=1, a consume drives `trap_req`=1 combinationally in the same cycle and puts the consumed register's number on `trap_reg`. In that case `status` is not altered.
- R8: Status bits stay set through later reads and writes. They fall only when software writes ones to them through `stat_clr_en`/`stat_clr_mask`. A set and a clear of the same bit in one cycle leave it set.
- R9: When both ports consume poisoned registers in the same cycle, `trap_reg` reports the lower register number.
- R10: Register 0 always reads as zero with poison bit 0, and writes to it have no effect.
- R11: Reset clears all poison bits, all status bits and `trap_en`.
- R12: When `mark_wr_en` and a normal write affect the same poison bit in one cycle, the value from `mark_wr_data` wins. The normal write still stores its data.
- R13: `ctl_wr_en` loads `ctl_trap_en` into `trap_en` at the clock edge. Reads are combinational, and a read in the same cycle as a write to the same register returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_addr | input | AW | Read port A register number |
| ra_use | input | 1 | Port A is consuming its operand this cycle |
| ra_data | output | DW | Port A data |
| ra_poison | output | 1 | Port A register's poison bit |
| rb_addr | input | AW | Read port B register number |
| rb_use | input | 1 | Port B is consuming its operand this cycle |
| rb_data | output | DW | Port B data |
| rb_poison | output | 1 | Port B register's poison bit |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write register number |
| wr_data | input | DW | Write data |
| wr_fault | input | 1 | Producing operation faulted |
| mark_wr_en | input | 1 | Restore all poison bits |
| mark_wr_data | input | NREG | Poison bits to restore |
| mark_rd | output | NREG | All poison bits |
| ctl_wr_en | input | 1 | Load trap enable |
| ctl_trap_en | input | 1 | New trap enable value |
| trap_en | output | 1 | Current trap enable |
| stat_clr_en | input | 1 | Clear status bits |
| stat_clr_mask | input | NREG | Ones select status bits to clear |
| status | output | NREG | Sticky per-register fault status |
| trap_req | output | 1 | Trap request for a consumed poisoned register |
| trap_reg | output | AW | Register that caused the trap |

## Verification
The bench aims at the following corner cases.
- Same-cycle collisions: a restore of the poison bits coincides with a faulting write to the same register. A design with the priority reversed leaves that register poisoned.
- Simultaneous consumes on both ports, in both address orders: a design that favours one port instead of the lower number reports the wrong register.
- Stickiness of status: after later clean writes and reads, the status bit must remain set, and it must drop only through the write-one clear. A design that ties status to the poison bit loses the record.
- Register 0: it is written with a fault and restored with its poison bit set. A design that fails to mask it shows data or a mark there.

// File: rtl/poisoned_regfile.sv
module poisoned_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NREG)-1:0]  ra_addr,
  input  logic                     ra_use,
  output logic [DW-1:0]            ra_data,
  output logic                     ra_poison,
  input  logic [$clog2(NREG)-1:0]  rb_addr,
  input  logic                     rb_use,
  output logic [DW-1:0]            rb_data,
  output logic                     rb_poison,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     wr_fault,
  input  logic                     mark_wr_en,
  input  logic [NREG-1:0]          mark_wr_data,
  output logic [NREG-1:0]          mark_rd,
  input  logic                     ctl_wr_en,
  input  logic                     ctl_trap_en,
  output logic                     trap_en,
  input  logic                     stat_clr_en,
  input  logic [NREG-1:0]          stat_clr_mask,
  output logic [NREG-1:0]          status,
  output logic                     trap_req,
  output logic [$clog2(NREG)-1:0]  trap_reg
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] poison_q, poison_d, status_q, status_d;
  logic            enable_q;

  wire hit_a = ra_use & poison_q[ra_addr];
  wire hit_b = rb_use & poison_q[rb_addr];

  assign ra_data   = (ra_addr == '0) ? '0 : mem[ra_addr];
  assign rb_data   = (rb_addr == '0) ? '0 : mem[rb_addr];
  assign ra_poison = poison_q[ra_addr];
  assign rb_poison = poison_q[rb_addr];
  assign mark_rd   = poison_q;
  assign status    = status_q;
  assign trap_en   = enable_q;
  assign trap_req  = enable_q & (hit_a | hit_b);

  always_comb begin
    if (hit_a && hit_b) trap_reg = (ra_addr < rb_addr) ? ra_addr : rb_addr;
    else if (hit_a)     trap_reg = ra_addr;
    else                trap_reg = rb_addr;
  end

  always_comb begin
    poison_d = poison_q;
    if (wr_en) poison_d[wr_addr] = wr_fault;
    if (mark_wr_en) poison_d = mark_wr_data;
    poison_d[0] = 1'b0;
  end

  always_comb begin
    status_d = status_q;
    if (stat_clr_en) status_d = status_d & ~stat_clr_mask;
    if (!enable_q) begin
      if (hit_a) status_d[ra_addr] = 1'b1;
      if (hit_b) status_d[rb_addr] = 1'b1;
    end
    status_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr != '0) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poison_q <= '0;
      status_q <= '0;
      enable_q <= 1'b0;
    end else begin
      poison_q <= poison_d;
      status_q <= status_d;
      if (ctl_wr_en) enable_q <= ctl_trap_en;
    end
  end

  assert_fault_marks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fault && wr_addr != '0 && !mark_wr_en) |=> mark_rd[$past(wr_addr)]);

  assert_clean_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_fault && !mark_wr_en) |=> !mark_rd[$past(wr_addr)]);

  assert_restore_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mark_wr_en |=> (mark_rd[NREG-1:1] == $past(mark_wr_data[NREG-1:1])));

  assert_quiet_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_en |-> !trap_req);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_clr_en |=> ((status & $past(status)) == $past(status)));

  assert_precise_no_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_en && !stat_clr_en) |=> $stable(status));

  assert_zero_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mark_rd[0]);
endmodule

// File: tb/poisoned_regfile_bench.sv
module poisoned_regfile_bench;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int AW   = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic ra_use = 0, rb_use = 0, wr_en = 0, wr_fault = 0;
  logic [DW-1:0] wr_data = '0, ra_data, rb_data;
  logic ra_poison, rb_poison;
  logic mark_wr_en = 0;
  logic [NREG-1:0] mark_wr_data = '0, mark_rd;
  logic ctl_wr_en = 0, ctl_trap_en = 0, trap_en;
  logic stat_clr_en = 0;
  logic [NREG-1:0] stat_clr_mask = '0, status;
  logic trap_req;
  logic [AW-1:0] trap_reg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  poisoned_regfile #(.NREG(NREG), .DW(DW)) u_poisoned_regfile (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(ra_addr), .ra_use(ra_use), .ra_data(ra_data), .ra_poison(ra_poison),
    .rb_addr(rb_addr), .rb_use(rb_use), .rb_data(rb_data), .rb_poison(rb_poison),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_fault(wr_fault),
    .mark_wr_en(mark_wr_en), .mark_wr_data(mark_wr_data), .mark_rd(mark_rd),
    .ctl_wr_en(ctl_wr_en), .ctl_trap_en(ctl_trap_en), .trap_en(trap_en),
    .stat_clr_en(stat_clr_en), .stat_clr_mask(stat_clr_mask), .status(status),
    .trap_req(trap_req), .trap_reg(trap_reg));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic f);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; wr_fault = f;
    #1 chk_eq("R1 no trap at write", {63'd0, trap_req}, 64'd0);
    @(posedge clk); #1;
    wr_en = 0; wr_fault = 0;
  endtask

  task automatic set_enable(input logic v);
    @(negedge clk);
    ctl_wr_en = 1; ctl_trap_en = v;
    @(posedge clk); #1;
    ctl_wr_en = 0;
  endtask

  task automatic clear_status(input logic [NREG-1:0] m);
    @(negedge clk);
    stat_clr_en = 1; stat_clr_mask = m;
    @(posedge clk); #1;
    stat_clr_en = 0; stat_clr_mask = '0;
  endtask

  task automatic consume(input logic [AW-1:0] a, input logic ua, input logic [AW-1:0] b, input logic ub);
    @(negedge clk);
    ra_addr = a; ra_use = ua; rb_addr = b; rb_use = ub;
    #1;
  endtask

  task automatic end_consume;
    @(posedge clk); #1;
    ra_use = 0; rb_use = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk_eq("R11 trap_en", {63'd0, trap_en}, 64'd0);
    chk_eq("R11 marks", {48'd0, mark_rd}, 64'd0);
    chk_eq("R11 status", {48'd0, status}, 64'd0);
    chk_eq("R11 trap_req", {63'd0, trap_req}, 64'd0);
  endtask

  task automatic t_fault_write;
    write_reg(4'd3, 32'hA5A5_0003, 1'b1);
    consume(4'd3, 1'b0, 4'd0, 1'b0);
    chk_eq("R1 data kept", {32'd0, ra_data}, 64'hA5A5_0003);
    chk_eq("R1 poison set", {63'd0, ra_poison}, 64'd1);
    chk_eq("R3 mark vector", {48'd0, mark_rd}, 64'h0008);
    end_consume();
  endtask

  task automatic t_clean_write;
    write_reg(4'd3, 32'h1111_2222, 1'b0);
    consume(4'd3, 1'b0, 4'd3, 1'b0);
    chk_eq("R2 poison cleared", {63'd0, rb_poison}, 64'd0);
    chk_eq("R2 data", {32'd0, rb_data}, 64'h1111_2222);
    end_consume();
  endtask

  task automatic t_disabled_record;
    write_reg(4'd5, 32'h55, 1'b1);
    consume(4'd5, 1'b1, 4'd0, 1'b0);
    chk_eq("R5 no trap while disabled", {63'd0, trap_req}, 64'd0);
    end_consume();
    chk_eq("R5 R6 status single bit", {48'd0, status}, 64'h0020);
  endtask

  task automatic t_sticky;
    write_reg(4'd5, 32'h56, 1'b0);
    consume(4'd5, 1'b1, 4'd2, 1'b1);
    end_consume();
    repeat (3) @(posedge clk);
    #1 chk_eq("R8 status persists", {48'd0, status}, 64'h0020);
    clear_status(16'h0010);
    chk_eq("R8 unrelated clear keeps bit", {48'd0, status}, 64'h0020);
    write_reg(4'd6, 32'h66, 1'b1);
    consume(4'd6, 1'b1, 4'd0, 1'b0);
    stat_clr_en = 1; stat_clr_mask = 16'h0040;
    end_consume();
    stat_clr_en = 0; stat_clr_mask = '0;
    chk_eq("R8 set beats clear", {48'd0, status}, 64'h0060);
    clear_status(16'h0060);
    chk_eq("R8 cleared by mask", {48'd0, status}, 64'h0000);
  endtask

  task automatic t_enabled_trap;
    set_enable(1'b1);
    chk_eq("R13 enable loaded", {63'd0, trap_en}, 64'd1);
    write_reg(4'd5, 32'h77, 1'b1);
    consume(4'd0, 1'b0, 4'd5, 1'b1);
    chk_eq("R7 trap same cycle", {63'd0, trap_req}, 64'd1);
    chk_eq("R7 trap register", {60'd0, trap_reg}, 64'd5);
    end_consume();
    chk_eq("R7 status untouched", {48'd0, status}, 64'h0000);
    consume(4'd5, 1'b0, 4'd5, 1'b0);
    chk_eq("R7 no trap without use", {63'd0, trap_req}, 64'd0);
    end_consume();
  endtask

  task automatic t_lowest;
    write_reg(4'd9, 32'h99, 1'b1);
    consume(4'd9, 1'b1, 4'd6, 1'b1);
    chk_eq("R9 lower on port B", {60'd0, trap_reg}, 64'd6);
    end_consume();
    consume(4'd5, 1'b1, 4'd9, 1'b1);
    chk_eq("R9 lower on port A", {60'd0, trap_reg}, 64'd5);
    end_consume();
    consume(4'd2, 1'b1, 4'd9, 1'b1);
    chk_eq("R9 single hit", {60'd0, trap_reg}, 64'd9);
    end_consume();
  endtask

  task automatic t_restore;
    @(negedge clk);
    mark_wr_en = 1; mark_wr_data = 16'hF0F1;
    @(posedge clk); #1;
    mark_wr_en = 0;
    chk_eq("R4 R10 whole restore", {48'd0, mark_rd}, 64'hF0F0);
    consume(4'd9, 1'b0, 4'd4, 1'b0);
    chk_eq("R4 newly marked", {63'd0, rb_poison}, 64'd1);
    chk_eq("R4 cleared mark", {63'd0, ra_poison}, 64'd0);
    chk_eq("R4 data unaffected", {32'd0, ra_data}, 64'h99);
    end_consume();
  endtask

  task automatic t_priority;
    @(negedge clk);
    mark_wr_en = 1; mark_wr_data = 16'h0000;
    wr_en = 1; wr_addr = 4'd7; wr_data = 32'h7777; wr_fault = 1;
    @(posedge clk); #1;
    mark_wr_en = 0; wr_en = 0; wr_fault = 0;
    consume(4'd7, 1'b0, 4'd0, 1'b0);
    chk_eq("R12 restore wins", {63'd0, ra_poison}, 64'd0);
    chk_eq("R12 data still written", {32'd0, ra_data}, 64'h7777);
    end_consume();
  endtask

  task automatic t_zero;
    write_reg(4'd0, 32'hDEAD, 1'b1);
    consume(4'd0, 1'b1, 4'd0, 1'b1);
    chk_eq("R10 zero data", {32'd0, ra_data}, 64'd0);
    chk_eq("R10 zero unmarked", {63'd0, rb_poison}, 64'd0);
    chk_eq("R10 no trap", {63'd0, trap_req}, 64'd0);
    end_consume();
  endtask

  task automatic t_read_old;
    @(negedge clk);
    wr_en = 1; wr_addr = 4'd3; wr_data = 32'hBEEF; wr_fault = 0;
    ra_addr = 4'd3;
    #1 chk_eq("R13 old value same cycle", {32'd0, ra_data}, 64'h1111_2222);
    @(posedge clk); #1;
    wr_en = 0;
    chk_eq("R13 new value next cycle", {32'd0, ra_data}, 64'hBEEF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fault_write();
    t_clean_write();
    t_disabled_record();
    t_sticky();
    t_enabled_trap();
    t_lowest();
    t_restore();
    t_priority();
    t_zero();
    t_read_old();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule